// File: doc/BRIEF.md
# Byte-Lane Static Memory with Per-Lane Output Control

This block is a synthesizable model of a 16-bit static memory array that is addressed asynchronously. It sits behind the usual active-low controls: chip select, output enable, write enable, and one enable per byte lane. It splits the word into a low and a high byte lane. For each lane it works out whether the lane is in standby, quiet, read or write. It then reads that lane, writes it, or leaves it floating, independently of the other lane. Write enable takes priority over output enable.

The block does not drive a tristate bus. It returns the read word on a dedicated output and raises one drive flag per lane, and the surrounding logic uses these flags to enable its own pad drivers. Write data arrives on a separate input bus and is committed on the rising system clock edge while the write conditions hold, so the model maps onto ordinary FPGA block or distributed memory. Read data is combinational by default. Setting a parameter adds one register stage on the data and the drive flags. The address width is a parameter: 18 bits gives the full 262,144-word array, and the default is kept small for elaboration.

Top module: `sram16_core`

## Requirements
- R1: While `sel_n` is high, both `lane_drive` bits are 0 and no lane is written, whatever the other controls are.
- R2: `active` is 1 exactly when `sel_n` is 0, and 0 otherwise.
- R3: With `sel_n`=0, `rd_en_n`=0, `wr_en_n`=1 and both byte enables 0, `lane_drive` is 2'b11 and `rdata` equals the full word stored at `addr`.
- R4: In a read, `lane_drive[0]` (bits 7:0) is 1 only when `lo_en_n` is 0, and `lane_drive[1]` (bits 15:8) is 1 only when `hi_en_n` is 0.
- R5: On a rising `clk` edge with `rst_n`=1, `sel_n`=0 and `wr_en_n`=0, every lane whose enable is 0 stores the matching byte of `wdata`. The value of `rd_en_n` has no effect on the write.
- R6: In a write, a lane whose enable is 1 keeps its previous byte. A write with both enables at 1 changes nothing.
- R7: While `sel_n`=0 and `wr_en_n`=0, both `lane_drive` bits are 0, even when `rd_en_n` is 0.
- R8: With `sel_n`=0, `rd_en_n`=1 and `wr_en_n`=1, `active` is 1 and both `lane_drive` bits are 0.
- R9: A stored byte stays unchanged through standby, reads and writes to other addresses, including the lowest and highest address, until it is written again.
- R10: Any lane whose `lane_drive` bit is 0 shows 0 on its byte of `rdata`.
- R11: While `rst_n` is 0, write controls do not change the array (and the optional output register is cleared).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples writes |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address |
| sel_n | input | 1 | Active-low chip select |
| rd_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| lo_en_n | input | 1 | Active-low enable for bits 7:0 |
| hi_en_n | input | 1 | Active-low enable for bits 15:8 |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, 0 on lanes that are not driven |
| lane_drive | output | 2 | Per-lane drive flag, bit 0 is the low byte |
| active | output | 1 | High while the chip is selected |

## Verification
The assertions take the controls and address to be stable between rising edges, with any change made away from the edge. This is how an asynchronous part is used when a clock samples its write strobe. The write-then-read property also assumes that a read following a write to the same address comes in the very next cycle. The bench changes every input only on the falling edge. It samples outputs one nanosecond later, before the next rising edge, so each write lands at a known edge and each read sees the array as that edge left it.

// File: rtl/sram16_pkg.sv
// Shared constants and the per-lane operating mode type.
// Assumes exactly two byte lanes, each eight bits wide.
package sram16_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        LANE_STANDBY = 2'd0,
        LANE_QUIET   = 2'd1,
        LANE_READ    = 2'd2,
        LANE_WRITE   = 2'd3
    } lane_mode_e;
endpackage

// File: rtl/sram16_decode.sv
// Decodes the control pins into one mode per byte lane.
// Assumes active-low controls. Write enable outranks output enable.
module sram16_decode
    import sram16_pkg::*;
(
    input  logic             sel_n,
    input  logic             rd_en_n,
    input  logic             wr_en_n,
    input  logic [LANES-1:0] be_n,
    output lane_mode_e       mode [LANES]
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Pick this lane's mode from the control truth table.
        always_comb begin
            if (sel_n)
                mode[g] = LANE_STANDBY;
            else if (!wr_en_n)
                mode[g] = be_n[g] ? LANE_QUIET : LANE_WRITE;
            else if (!rd_en_n && !be_n[g])
                mode[g] = LANE_READ;
            else
                mode[g] = LANE_QUIET;
        end
    end
endmodule

// File: rtl/sram16_lane.sv
// One byte lane of storage. Writes commit on the clock edge, and the read
// is combinational and gated to zero when the lane is not being read.
// Assumes addr is held stable around the edge. The array is never reset.
module sram16_lane
    import sram16_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  lane_mode_e        mode,
    input  logic [W-1:0]      wbyte,
    output logic [W-1:0]      rbyte,
    output logic              drive
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0] store [DEPTH];

    // Commit the byte on the edge while the lane is in write mode and out of reset.
    always_ff @(posedge clk) begin
        if (rst_n && mode == LANE_WRITE)
            store[addr] <= wbyte;
    end

    // Present the addressed byte only while the lane is being read.
    always_comb begin
        drive = (mode == LANE_READ);
        rbyte = drive ? store[addr] : '0;
    end
endmodule

// File: rtl/sram16_outstage.sv
// Optional output register for read data and drive flags.
// REG_OUT=0 passes them straight through. REG_OUT=1 adds one cycle,
// cleared by the synchronous reset.
module sram16_outstage #(
    parameter int REG_OUT = 0,
    parameter int W       = 16,
    parameter int N       = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    input  logic [N-1:0] oe_in,
    output logic [W-1:0] d_out,
    output logic [N-1:0] oe_out
);
    if (REG_OUT != 0) begin : g_reg
        // Hold the read word and lane flags for one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_out  <= '0;
                oe_out <= '0;
            end else begin
                d_out  <= d_in;
                oe_out <= oe_in;
            end
        end
    end else begin : g_pass
        logic unused_ok;
        // Pass through. The clock and reset are unused in this variant.
        always_comb begin
            d_out     = d_in;
            oe_out    = oe_in;
            unused_ok = clk ^ rst_n;
        end
    end
endmodule

// File: rtl/sram16_core.sv
// Top level: a two-lane 16-bit static memory with per-lane drive flags
// in place of tristate pins. Assumes inputs change away from the rising
// clock edge.
module sram16_core
    import sram16_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int REG_OUT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_n,
    input  logic              rd_en_n,
    input  logic              wr_en_n,
    input  logic              lo_en_n,
    input  logic              hi_en_n,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic [1:0]        lane_drive,
    output logic              active
);
    lane_mode_e          mode [LANES];
    logic [LANES-1:0]    be_n;
    logic [DATA_W-1:0]   rd_raw;
    logic [LANES-1:0]    oe_raw;

    // Gather the byte enables into a lane-indexed vector.
    always_comb be_n = {hi_en_n, lo_en_n};

    sram16_decode u_dec (
        .sel_n   (sel_n),
        .rd_en_n (rd_en_n),
        .wr_en_n (wr_en_n),
        .be_n    (be_n),
        .mode    (mode)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram16_lane #(.ADDR_W(ADDR_W), .W(LANE_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .addr  (addr),
            .mode  (mode[g]),
            .wbyte (wdata[g*LANE_W +: LANE_W]),
            .rbyte (rd_raw[g*LANE_W +: LANE_W]),
            .drive (oe_raw[g])
        );
    end

    sram16_outstage #(.REG_OUT(REG_OUT), .W(DATA_W), .N(LANES)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (rd_raw),
        .oe_in  (oe_raw),
        .d_out  (rdata),
        .oe_out (lane_drive)
    );

    // Report the selected (non-standby) state.
    always_comb active = !sel_n;
endmodule

// File: rtl/sram16_core_chk.sv
// Checker bound to sram16_core: relates the control pins to the drive
// flags and read data. Assumes inputs are stable across each rising edge.
module sram16_core_chk #(
    parameter int ADDR_W  = 10,
    parameter int REG_OUT = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              sel_n,
    input logic              rd_en_n,
    input logic              wr_en_n,
    input logic              lo_en_n,
    input logic              hi_en_n,
    input logic [15:0]       wdata,
    input logic [15:0]       rdata,
    input logic [1:0]        lane_drive,
    input logic              active
);
    if (REG_OUT == 0) begin : g_comb
        // R1
        standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sel_n |-> (lane_drive == 2'b00 && !active));
        // R7
        write_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_n && !wr_en_n) |-> lane_drive == 2'b00);
        // R8
        outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_n && rd_en_n && wr_en_n) |-> (active && lane_drive == 2'b00));
        // R4
        lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_drive[0] |-> !lo_en_n) and (lane_drive[1] |-> !hi_en_n));
        // R10
        float_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!lane_drive[0] |-> rdata[7:0] == 8'h00) and (!lane_drive[1] |-> rdata[15:8] == 8'h00));
        // R5
        write_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!sel_n && !wr_en_n && !lo_en_n)
             && !sel_n && wr_en_n && !rd_en_n && !lo_en_n && addr == $past(addr))
            |-> rdata[7:0] == $past(wdata[7:0]));
    end else begin : g_reg
        // R1
        standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(sel_n)) |-> lane_drive == 2'b00);
        // R7
        write_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!sel_n && !wr_en_n)) |-> lane_drive == 2'b00);
        // R2
        active_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            active != sel_n);
        // R10
        float_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!lane_drive[0] |-> rdata[7:0] == 8'h00) and (!lane_drive[1] |-> rdata[15:8] == 8'h00));
        logic unused_ok;
        always_comb unused_ok = ^{addr, rd_en_n, lo_en_n, hi_en_n, wdata};
    end
endmodule

bind sram16_core sram16_core_chk #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .sel_n      (sel_n),
    .rd_en_n    (rd_en_n),
    .wr_en_n    (wr_en_n),
    .lo_en_n    (lo_en_n),
    .hi_en_n    (hi_en_n),
    .wdata      (wdata),
    .rdata      (rdata),
    .lane_drive (lane_drive),
    .active     (active)
);

// File: tb/sram16_core_test.sv
// Vector-table bench for sram16_core with a combinational read path.
module sram16_core_test;
    localparam int ADDR_W = 10;
    localparam int NV     = 16;

    typedef struct packed {
        logic [4:0]  ctl;     // {sel_n, rd_en_n, wr_en_n, lo_en_n, hi_en_n}
        logic [7:0]  adr;
        logic [15:0] wd;
        logic [1:0]  exp_oe;
        logic        exp_act;
        logic [15:0] exp_rd;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{5'b01000, 8'd1, 16'h1234, 2'b00, 1'b1, 16'h0000, 4'd5},  // R5 write both lanes
        '{5'b00100, 8'd1, 16'h0000, 2'b11, 1'b1, 16'h1234, 4'd3},  // R3 full read
        '{5'b00001, 8'd1, 16'hABCD, 2'b00, 1'b1, 16'h0000, 4'd7},  // R7 low write, oe low
        '{5'b00100, 8'd1, 16'h0000, 2'b11, 1'b1, 16'h12CD, 4'd6},  // R6 high byte kept
        '{5'b01010, 8'd2, 16'h5AA5, 2'b00, 1'b1, 16'h0000, 4'd5},  // R5 high only
        '{5'b01001, 8'd2, 16'h0033, 2'b00, 1'b1, 16'h0000, 4'd5},  // R5 low only
        '{5'b00101, 8'd1, 16'h0000, 2'b01, 1'b1, 16'h00CD, 4'd4},  // R4 low read
        '{5'b00110, 8'd1, 16'h0000, 2'b10, 1'b1, 16'h1200, 4'd4},  // R4 high read
        '{5'b10000, 8'd1, 16'hFFFF, 2'b00, 1'b0, 16'h0000, 4'd1},  // R1 standby write
        '{5'b00100, 8'd1, 16'h0000, 2'b11, 1'b1, 16'h12CD, 4'd1},  // R1 write ignored
        '{5'b01100, 8'd2, 16'h0000, 2'b00, 1'b1, 16'h0000, 4'd8},  // R8 outputs off
        '{5'b00100, 8'd2, 16'h0000, 2'b11, 1'b1, 16'h5A33, 4'd9},  // R9 persists
        '{5'b00111, 8'd2, 16'h0000, 2'b00, 1'b1, 16'h0000, 4'd10}, // R10 no lanes
        '{5'b01011, 8'd2, 16'h0000, 2'b00, 1'b1, 16'h0000, 4'd6},  // R6 empty write
        '{5'b00100, 8'd2, 16'h0000, 2'b11, 1'b1, 16'h5A33, 4'd6},  // R6 unchanged
        '{5'b10100, 8'd2, 16'h0000, 2'b00, 1'b0, 16'h0000, 4'd2}   // R2 deselected
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic              sel_n, rd_en_n, wr_en_n, lo_en_n, hi_en_n;
    logic [15:0]       wdata;
    logic [15:0]       rdata;
    logic [1:0]        lane_drive;
    logic              active;
    int                n_chk  = 0;
    int                n_fail = 0;
    bit                done   = 1'b0;

    always #2 clk = ~clk;

    sram16_core #(.ADDR_W(ADDR_W), .REG_OUT(0)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .rd_en_n(rd_en_n),
        .wr_en_n(wr_en_n), .lo_en_n(lo_en_n), .hi_en_n(hi_en_n), .wdata(wdata),
        .rdata(rdata), .lane_drive(lane_drive), .active(active)
    );

    task automatic drive(input logic [4:0] c, input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(negedge clk);
        {sel_n, rd_en_n, wr_en_n, lo_en_n, hi_en_n} = c;
        addr  = a;
        wdata = d;
        #1;
    endtask

    task automatic check(input string req, input logic [1:0] eo, input logic ea, input logic [15:0] er);
        n_chk++;
        if (lane_drive !== eo || active !== ea || rdata !== er) begin
            n_fail++;
            $display("FAIL %s: got drive=%b active=%b rdata=%h, expected drive=%b active=%b rdata=%h",
                     req, lane_drive, active, rdata, eo, ea, er);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        // R11 reset state with the chip deselected; R2 active low
        drive(5'b10000, '0, 16'h0000);
        drive(5'b10100, '0, 16'h0000);
        check("R11", 2'b00, 1'b0, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].ctl, ADDR_W'(VECS[i].adr), VECS[i].wd);
            check($sformatf("R%0d", VECS[i].req), VECS[i].exp_oe, VECS[i].exp_act, VECS[i].exp_rd);
        end

        // R11 a write attempted during reset leaves the word intact
        rst_n = 1'b0;
        drive(5'b01000, 10'd1, 16'hEEEE);
        drive(5'b10100, 10'd1, 16'h0000);
        rst_n = 1'b1;
        drive(5'b00100, 10'd1, 16'h0000);
        check("R11", 2'b11, 1'b1, 16'h12CD);

        // R9 lowest and highest addresses hold independent words
        drive(5'b01000, '0, 16'h0F0F);
        drive(5'b01000, '1, 16'hF0F0);
        drive(5'b00100, '0, 16'h0000);
        check("R9", 2'b11, 1'b1, 16'h0F0F);
        drive(5'b00100, '1, 16'h0000);
        check("R9", 2'b11, 1'b1, 16'hF0F0);

        // R2 selection alone raises active
        drive(5'b01111, '0, 16'h0000);
        check("R2", 2'b00, 1'b1, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule